// File: doc/BRIEF.md
# Bus Error Interrupt Aggregator

This block holds a 32-bit host-accessible configuration word and uses part of it to funnel six bus-error status flags into a single internal interrupt status bit. Each flag has its own enable bit in the word. When an enabled flag goes from 0 to 1, a small two-state machine moves from `IDLE` to `PENDING`, and the internal status bit reads 1. The status bit is sticky. It returns to 0 only when software pulses the write-one-to-clear input.

A separate master enable bit in the same word gates the physical active-low interrupt pin. The pin is pulled low only while the machine is in `PENDING` and the master enable is 1. The host writes the word one byte lane at a time under byte enables. Two bits are reserved: they always read as zero and ignore writes. The other non-enable bits are plain read/write storage for fields that neighbouring logic decodes.

The state machine has two states, `IDLE` (status 0) and `PENDING` (status 1), and three transitions:
- `IDLE -> PENDING` (set): taken on any enabled rising edge.
- `PENDING -> IDLE` (clear): taken on a clear pulse with no enabled rising edge in the same cycle.
- `PENDING -> PENDING` (hold): taken otherwise, including a clear and a set in the same cycle.

Top module: `bus_err_irq_agg`

## Requirements
- R1: After reset, `rd_data` is 0x00000000, `irq_status` is 0 and `irq_n` is 1.
- R2: A write with `wr_en` high updates byte lane k (bits 8k+7..8k) from `wr_data` only where `wr_be[k]` is 1. Other lanes, and all lanes when `wr_en` is low, keep their value. The new value is visible on `rd_data` after the clock edge.
- R3: Bits 26:25 of `rd_data` always read 0, whatever is written to them.
- R4: Flag `err_flags[i]` has its enable at bit position 31, 30, 29, 28, 27, 24 for i = 0..5. A 0-to-1 change of `err_flags[i]` between two consecutive clock edges, with its enable bit 1 at the second edge, sets `irq_status` to 1 after that edge (`IDLE -> PENDING`).
- R5: A flag whose enable bit is 0 has no effect on `irq_status`. A flag that stays high does not set it, including when its enable is turned on while the flag is already high.
- R6: Once set, `irq_status` stays 1 for as long as `stat_clr` is low.
- R7: A `stat_clr` pulse with no enabled rising edge in the same cycle returns `irq_status` to 0 after the edge (`PENDING -> IDLE`).
- R8: When an enabled rising edge and `stat_clr` occur in the same cycle, `irq_status` is 1 after the edge.
- R9: `irq_n` is 0 exactly when `irq_status` is 1 and bit 23 of the register is 1. It follows either condition without added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| err_flags | input | 6 | Bus-error status flags (level) |
| stat_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| irq_status | output | 1 | Sticky internal interrupt status |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The bench targets four cases, each tied to a specific design error:
- An enable turned on while its flag is already high must not set the status. A design that tested levels rather than edges would set it here.
- A clear that coincides with a fresh enabled edge must leave the status set. A design with clear priority would drop that event.
- With the master enable off, the status must still set while the pin stays high. A design that merged the two bits would fail this.
- Partial byte-enable writes and writes to the reserved pair must behave as specified. A lane decoder that is off by one, or a missing reserved mask, would show up on the readback.

Long random runs mix flag toggles, writes and clear pulses against a bench-side model.

// File: rtl/bus_err_irq_pkg.sv
package bus_err_irq_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned NUM_SRC    = 6;
    localparam int unsigned MASTER_POS = 23;
    localparam logic [REG_W-1:0] RSVD_MASK = 32'h0600_0000;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } agg_state_e;

    // bit position of the enable for source i
    function automatic int unsigned src_pos(input int unsigned i);
        case (i)
            0:       return 31;
            1:       return 30;
            2:       return 29;
            3:       return 28;
            4:       return 27;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/bei_cfg_reg.sv
module bei_cfg_reg #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] RO_MASK = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     cfg_q
);
    localparam int unsigned NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] cfg_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_be[b]) begin
                    cfg_r[b*8 +: 8] <= wr_data[b*8 +: 8] & ~RO_MASK[b*8 +: 8];
                end
            end
        end
    end

    assign cfg_q = cfg_r & ~RO_MASK;

endmodule

// File: rtl/bei_src_detect.sv
module bei_src_detect #(
    parameter int unsigned NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] src_en,
    output logic            any_set
);
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_edge
        assign rise[i] = flags[i] & ~flags_q[i] & src_en[i];
    end

    assign any_set = |rise;

endmodule

// File: rtl/bei_status_fsm.sv
module bei_status_fsm
    import bus_err_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic master_en,
    output logic status,
    output logic pin_n
);
    agg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (set_evt)              state_d = ST_PENDING;
            ST_PENDING: if (clr_evt && !set_evt)  state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_PENDING: begin
                status = 1'b1;
                pin_n  = ~master_en;
            end
            default: begin
                status = 1'b0;
                pin_n  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bus_err_irq_agg.sv
module bus_err_irq_agg
    import bus_err_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          wr_be,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    input  logic [5:0]          err_flags,
    input  logic                stat_clr,
    output logic                irq_status,
    output logic                irq_n
);
    logic [REG_W-1:0]   cfg_q;
    logic [NUM_SRC-1:0] src_en;
    logic               any_set;

    bei_cfg_reg #(
        .DATA_W  (REG_W),
        .RO_MASK (RSVD_MASK)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        assign src_en[i] = cfg_q[src_pos(i)];
    end

    bei_src_detect #(
        .NSRC (NUM_SRC)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (err_flags),
        .src_en  (src_en),
        .any_set (any_set)
    );

    bei_status_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (any_set),
        .clr_evt   (stat_clr),
        .master_en (cfg_q[MASTER_POS]),
        .status    (irq_status),
        .pin_n     (irq_n)
    );

    assign rd_data = cfg_q;

endmodule

// File: rtl/bei_checker.sv
module bei_checker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] rd_data,
    input  logic [5:0]  err_flags,
    input  logic        stat_clr,
    input  logic        irq_status,
    input  logic        irq_n
);
    logic [5:0] prev_f;
    logic [5:0] en_v;
    logic       rise_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_f <= '0;
        else        prev_f <= err_flags;
    end

    assign en_v     = {rd_data[24], rd_data[27], rd_data[28],
                       rd_data[29], rd_data[30], rd_data[31]};
    assign rise_any = |(err_flags & ~prev_f & en_v);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[26:25] == 2'b00);                                      // R3
    AST_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(irq_status && rd_data[23]));                        // R9
    AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any |=> irq_status);                                      // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !stat_clr) |=> irq_status);                     // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rise_any) |=> !irq_status);                      // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_status && !rise_any) |=> !irq_status);                   // R5
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));                                  // R2
    AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[0]) |=> $stable(rd_data[7:0]));               // R2

endmodule

bind bus_err_irq_agg bei_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_be      (wr_be),
    .rd_data    (rd_data),
    .err_flags  (err_flags),
    .stat_clr   (stat_clr),
    .irq_status (irq_status),
    .irq_n      (irq_n)
);

// File: tb/bus_err_irq_agg_tb.sv
`timescale 1ns/1ps
module bus_err_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  err_flags = '0;
    logic        stat_clr = 1'b0;
    logic        irq_status;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_reg  = '0;
    logic [5:0]  m_prev = '0;
    logic        m_stat = 1'b0;

    always #2.5 clk = ~clk;

    bus_err_irq_agg u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_be (wr_be),
        .wr_data (wr_data), .rd_data (rd_data), .err_flags (err_flags),
        .stat_clr (stat_clr), .irq_status (irq_status), .irq_n (irq_n)
    );

    function automatic logic [5:0] enables(input logic [31:0] r);
        return {r[24], r[27], r[28], r[29], r[30], r[31]};
    endfunction

    function automatic logic [31:0] apply_write(input logic [31:0] r,
            input logic [31:0] d, input logic [3:0] be);
        logic [31:0] n = r;
        for (int k = 0; k < 4; k++) if (be[k]) n[k*8 +: 8] = d[k*8 +: 8];
        return n & ~32'h0600_0000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic we, input logic [3:0] be,
                        input logic [31:0] d, input logic [5:0] f,
                        input logic clr);
        logic rise;
        @(negedge clk);
        wr_en = we; wr_be = be; wr_data = d; err_flags = f; stat_clr = clr;
        rise   = |(f & ~m_prev & enables(m_reg));
        m_stat = rise ? 1'b1 : (clr ? 1'b0 : m_stat);
        if (we) m_reg = apply_write(m_reg, d, be);
        m_prev = f;
        @(posedge clk);
        #1;
        check({tag, " rd_data"}, rd_data, m_reg);
        check({tag, " irq_status"}, {31'b0, irq_status}, {31'b0, m_stat});
        check({tag, " irq_n"}, {31'b0, irq_n}, {31'b0, ~(m_stat & m_reg[23])});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        #1;
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 irq_status", {31'b0, irq_status}, 32'h0);
        check("R1 irq_n", {31'b0, irq_n}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        step("R3 all ones", 1, 4'hF, 32'hFFFF_FFFF, 6'h0, 0);
        check("R3 rsvd", {30'b0, rd_data[26:25]}, 32'h0);
        step("R2 lane1 clear", 1, 4'b0010, 32'h0, 6'h0, 0);
        check("R2 lane1 value", rd_data, 32'hF9FF_00FF);
        step("R2 no write", 0, 4'hF, 32'h0, 6'h0, 0);
        step("R2 clear all", 1, 4'hF, 32'h0, 6'h0, 0);
        // enable only source 2 (bit 29), master off
        step("R4 en src2", 1, 4'b1000, 32'h2000_0000, 6'h0, 0);
        step("R5 disabled src0", 0, 4'h0, 32'h0, 6'b000001, 0);
        step("R4 src2 rise", 0, 4'h0, 32'h0, 6'b000101, 0);
        check("R9 master off pin", {31'b0, irq_n}, 32'h1);
        step("R9 master on", 1, 4'b0100, 32'h0080_0000, 6'b000101, 0);
        check("R9 pin low", {31'b0, irq_n}, 32'h0);
        step("R6 hold", 0, 4'h0, 32'h0, 6'b000101, 0);
        step("R6 hold2", 0, 4'h0, 32'h0, 6'b000000, 0);
        step("R7 clear", 0, 4'h0, 32'h0, 6'b000000, 1);
        check("R7 status", {31'b0, irq_status}, 32'h0);
        step("R8 set vs clr", 0, 4'h0, 32'h0, 6'b000100, 1);
        check("R8 status", {31'b0, irq_status}, 32'h1);
        step("R7 clear held", 0, 4'h0, 32'h0, 6'b000100, 1);
        step("R5 en while high", 1, 4'b1000, 32'hA000_0000, 6'b000101, 0);
        check("R5 no set", {31'b0, irq_status}, 32'h0);
        step("R4 src5 en", 1, 4'b0001, 32'h0000_0000, 6'b000101, 0);
        step("R4 src5 en bit24", 1, 4'b1000, 32'h0100_0000, 6'b000101, 0);
        step("R4 src5 rise", 0, 4'h0, 32'h0, 6'b100101, 0);
        check("R4 src5 status", {31'b0, irq_status}, 32'h1);

        for (int n = 0; n < 4000; n++) begin
            logic we;
            logic [5:0] f;
            we = ($urandom % 6) == 0;
            f  = err_flags ^ (6'($urandom) & 6'($urandom));
            step("R4-random", we, 4'($urandom), $urandom, f,
                 ($urandom % 7) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule